// File: doc/BRIEF.md
# LED Status Code Flasher

This block reports a small diagnostic status value on one LED. While reporting is enabled it sends the value as a frame of pulses, one pulse per bit, with the least significant bit first. Every bit slot has the same length. A bit slot opens with a short low lead-in and then a high pulse. A zero bit has a short pulse and a one bit has a long pulse. After the last bit the LED stays low for a long dead time, and the frame then starts again.

Code and enable are sampled only at a frame boundary, so a frame cannot change partway through. If reporting is withdrawn, the frame already on the LED is completed and the LED then stays dark. All timing figures are parameters counted in clock cycles. A reader decodes the value by telling long pulses from short ones.

Top module: `led_code_flasher`

## Requirements
- R1: A synchronous reset (`rst` high) forces the LED low at once and returns the block to idle. After reset is released, a frame starts at the first rising clock edge at which `show_en` is high.
- R2: While `show_en` is low and no frame is in progress, `led` stays low whatever value `status_code` holds.
- R3: A frame contains exactly `CODE_W` (default 4) high pulses. Bit 0 of the latched code is sent first and bit `CODE_W-1` last. Frame cycle t=0 is the first cycle after the sampling edge, and bit k occupies frame cycles k*`BIT_CYC` to (k+1)*`BIT_CYC`-1.
- R4: A zero bit is low for `LEAD_CYC` cycles, then high for `SHORT_HI` cycles, then low for the rest of its `BIT_CYC`-cycle slot.
- R5: A one bit is low for `LEAD_CYC` cycles, then high for `LONG_HI` cycles, then low for the rest of the same `BIT_CYC`-cycle slot. The parameters must satisfy `LEAD_CYC`+`LONG_HI` < `BIT_CYC` and `SHORT_HI` < `LONG_HI`.
- R6: After the last bit slot the LED is low for `DEAD_CYC` cycles. If `show_en` is high at the last dead-time edge, the next frame begins in the very next cycle.
- R7: `status_code` and `show_en` are sampled only at a frame boundary: the edge that leaves idle, or the last edge of the dead time. A change between boundaries has no effect on the frame in progress, and a code present at the boundary edge is the one used for the following frame.
- R8: If `show_en` is low at the last dead-time edge, the frame already in progress is still completed, and the LED then stays low. This holds even when `show_en` was high for a single cycle or dropped mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| show_en | input | 1 | Reporting enable, sampled at frame boundaries |
| status_code | input | CODE_W | Value to report, sampled at frame boundaries |
| led | output | 1 | LED drive, high = lit |

## Verification
Two events can fall on the same clock edge: the end of a dead time and a change at the inputs. The inputs may drop the enable, or present a new code, exactly on the last dead-time edge. The bench provokes this by changing `show_en` or `status_code` on the falling edge just before that final edge. It judges the outcome from the following frame or dark period. A new code must appear in the very next frame, and a withdrawal must leave the LED dark with no partial frame. Mid-frame changes are applied at an early point of the frame as a contrast, and must leave the current frame unchanged.

// File: rtl/flasher_pkg.sv
package flasher_pkg;

  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_BITS = 2'd1,
    FL_DEAD = 2'd2
  } fl_state_t;

  // High time of a bit slot, chosen by the bit value.
  function automatic int high_len(input logic one, input int short_hi, input int long_hi);
    return one ? long_hi : short_hi;
  endfunction

  // Whether a slot position falls inside the high window after the lead-in.
  function automatic logic pulse_on(input int pos, input int lead, input int width);
    return (pos >= lead) && (pos < lead + width);
  endfunction

endpackage

// File: rtl/flash_phase_timer.sv
module flash_phase_timer
  import flasher_pkg::*;
#(
  parameter int BIT_CYC  = 12,
  parameter int DEAD_CYC = 30,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  fl_state_t        state,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end
);

  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CYC - 1);
  localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);

  logic [CNT_W-1:0] limit_m1;

  always_comb begin
    limit_m1 = (state == FL_DEAD) ? DEAD_LAST : BIT_LAST;
    at_end   = (state != FL_IDLE) && (cnt == limit_m1);
  end

  // The count is held at zero while idle and wraps at the end of each phase.
  always_ff @(posedge clk) begin
    if (rst || state == FL_IDLE || at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/flash_sequencer.sv
module flash_sequencer
  import flasher_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              show_en,
  input  logic [CODE_W-1:0] status_code,
  input  logic              at_end,
  output fl_state_t         state,
  output logic [IDX_W-1:0]  bit_idx,
  output logic [CODE_W-1:0] code_q,
  output logic              frame_start,
  output logic              frame_end
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

  logic bit_end;
  logic last_bit;

  always_comb begin
    bit_end     = (state == FL_BITS) && at_end;
    last_bit    = bit_end && (bit_idx == LAST_IDX);
    frame_end   = (state == FL_DEAD) && at_end;
    frame_start = show_en && ((state == FL_IDLE) || frame_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FL_IDLE;
      bit_idx <= '0;
      code_q  <= '0;
    end else if (frame_start) begin
      // Only sampling point for the code and the enable.
      state   <= FL_BITS;
      bit_idx <= '0;
      code_q  <= status_code;
    end else if (frame_end) begin
      state   <= FL_IDLE;
    end else if (last_bit) begin
      state   <= FL_DEAD;
      bit_idx <= '0;
    end else if (bit_end) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/flash_shaper.sv
module flash_shaper
  import flasher_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 6,
  parameter int LEAD_CYC = 2,
  parameter int SHORT_HI = 2,
  parameter int LONG_HI  = 7
) (
  input  fl_state_t         state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [CODE_W-1:0] code_q,
  output logic              led
);

  int width;

  always_comb begin
    width = high_len(code_q[bit_idx], SHORT_HI, LONG_HI);
    led   = (state == FL_BITS) && pulse_on(int'(cnt), LEAD_CYC, width);
  end

endmodule

// File: rtl/led_code_flasher.sv
module led_code_flasher
  import flasher_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int BIT_CYC  = 12_500_000,
  parameter int LEAD_CYC = 1_250_000,
  parameter int SHORT_HI = 1_250_000,
  parameter int LONG_HI  = 8_750_000,
  parameter int DEAD_CYC = 50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              show_en,
  input  logic [CODE_W-1:0] status_code,
  output logic              led
);

  localparam int IDX_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam int SPAN   = (BIT_CYC > DEAD_CYC) ? BIT_CYC : DEAD_CYC;
  localparam int CNT_W  = $clog2(SPAN + 1);

  generate
    if (!(LEAD_CYC + LONG_HI < BIT_CYC) || !(SHORT_HI < LONG_HI) ||
        !(SHORT_HI > 0) || !(DEAD_CYC > 0)) begin : g_bad_timing
      $error("led_code_flasher: pulse timing parameters out of order");
    end
  endgenerate

  fl_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic              at_end;
  logic [IDX_W-1:0]  bit_idx;
  logic [CODE_W-1:0] code_q;
  logic              frame_start;
  logic              frame_end;

  flash_phase_timer #(
    .BIT_CYC (BIT_CYC),
    .DEAD_CYC(DEAD_CYC),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .cnt   (cnt),
    .at_end(at_end)
  );

  flash_sequencer #(
    .CODE_W(CODE_W),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .show_en    (show_en),
    .status_code(status_code),
    .at_end     (at_end),
    .state      (state),
    .bit_idx    (bit_idx),
    .code_q     (code_q),
    .frame_start(frame_start),
    .frame_end  (frame_end)
  );

  flash_shaper #(
    .CODE_W  (CODE_W),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .LEAD_CYC(LEAD_CYC),
    .SHORT_HI(SHORT_HI),
    .LONG_HI (LONG_HI)
  ) u_shape (
    .state  (state),
    .cnt    (cnt),
    .bit_idx(bit_idx),
    .code_q (code_q),
    .led    (led)
  );

endmodule

// File: rtl/flasher_checker.sv
module flasher_checker
  import flasher_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SHORT_HI = 2,
  parameter int LONG_HI  = 7,
  parameter int DEAD_CYC = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              show_en,
  input logic              led,
  input fl_state_t         state,
  input logic [CODE_W-1:0] code_q,
  input logic              frame_start,
  input logic              frame_end
);

  logic led_d;
  int   hi_cnt;
  int   rise_cnt;
  int   dead_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      led_d    <= 1'b0;
      hi_cnt   <= 0;
      rise_cnt <= 0;
      dead_cnt <= 0;
    end else begin
      led_d    <= led;
      hi_cnt   <= led ? hi_cnt + 1 : 0;
      dead_cnt <= (state == FL_DEAD) ? dead_cnt + 1 : 0;
      if (frame_start)      rise_cnt <= 0;
      else if (led && !led_d) rise_cnt <= rise_cnt + 1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == FL_IDLE && !led));

  assert_idle_dark_R2: assert property (@(posedge clk) disable iff (rst)
    (state == FL_IDLE) |-> !led);

  assert_four_pulses_R3: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (rise_cnt == CODE_W));

  // R4 and R5: every pulse is either the short or the long width
  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(led) |-> (hi_cnt == SHORT_HI || hi_cnt == LONG_HI));

  assert_dead_dark_R6: assert property (@(posedge clk) disable iff (rst)
    (state == FL_DEAD) |-> !led);

  assert_dead_length_R6: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (dead_cnt == DEAD_CYC - 1));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_end && show_en) |=> (state == FL_BITS));

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state != FL_IDLE && !frame_end) |=> $stable(code_q));

  assert_withdraw_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !show_en) |=> (state == FL_IDLE));

endmodule

bind led_code_flasher flasher_checker #(
  .CODE_W  (CODE_W),
  .SHORT_HI(SHORT_HI),
  .LONG_HI (LONG_HI),
  .DEAD_CYC(DEAD_CYC)
) u_flasher_chk (
  .clk        (clk),
  .rst        (rst),
  .show_en    (show_en),
  .led        (led),
  .state      (state),
  .code_q     (code_q),
  .frame_start(frame_start),
  .frame_end  (frame_end)
);

// File: tb/test_led_code_flasher.sv
module test_led_code_flasher;

  localparam int BIT_C   = 12;
  localparam int LEAD_C  = 2;
  localparam int SHORT_C = 2;
  localparam int LONG_C  = 7;
  localparam int DEAD_C  = 30;
  localparam int FRAME   = 4 * BIT_C + DEAD_C;

  // {code, number of long pulses expected}
  localparam logic [7:0] VEC [8] = '{8'h00, 8'h41, 8'hF4, 8'h11,
                                     8'h81, 8'hA2, 8'h52, 8'hE3};

  logic       clk = 1'b0;
  logic       rst;
  logic       show_en;
  logic [3:0] status_code;
  logic       led;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  led_code_flasher #(
    .CODE_W  (4),
    .BIT_CYC (BIT_C),
    .LEAD_CYC(LEAD_C),
    .SHORT_HI(SHORT_C),
    .LONG_HI (LONG_C),
    .DEAD_CYC(DEAD_C)
  ) i_led_code_flasher (
    .clk        (clk),
    .rst        (rst),
    .show_en    (show_en),
    .status_code(status_code),
    .led        (led)
  );

  task automatic check(input bit ok, input string req, input string detail);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  // Expected LED level at frame cycle t for a given code.
  function automatic logic model_led(input logic [3:0] c, input int t);
    int slot;
    int off;
    int hi;
    if (t >= 4 * BIT_C) return 1'b0;
    slot = t / BIT_C;
    off  = t - slot * BIT_C;
    hi   = c[slot] ? LONG_C : SHORT_C;
    return (off >= LEAD_C) && (off < LEAD_C + hi);
  endfunction

  task automatic expect_dark(input int n, input string req);
    int lit = 0;
    repeat (n) begin
      @(negedge clk);
      if (led !== 1'b0) lit++;
    end
    check(lit == 0, req, $sformatf("led high in %0d of %0d cycles, expected 0", lit, n));
  endtask

  // Called after inputs are set on a falling edge; the next rising edge
  // is the sampling edge and frame cycle 0 follows it.
  task automatic run_frame(input logic [3:0] code_x, input int nlong, input int act_t,
                           input logic act_en, input logic [3:0] act_code, input string req);
    int   bad = 0;
    int   bad_t = -1;
    logic bad_a = 1'b0;
    logic bad_e = 1'b0;
    int   run = 0;
    int   longs = 0;
    logic e;
    for (int t = 0; t < FRAME; t++) begin
      @(negedge clk);
      e = model_led(code_x, t);
      if (led !== e) begin
        if (bad == 0) begin
          bad_t = t; bad_a = led; bad_e = e;
        end
        bad++;
      end
      if (led === 1'b1) run++;
      else begin
        if (run == LONG_C) longs++;
        run = 0;
      end
      if (t == act_t) begin
        show_en     = act_en;
        status_code = act_code;
      end
    end
    check(bad == 0, req, $sformatf("code %h: %0d bad cycles, first t=%0d led=%b expected %b",
                                   code_x, bad, bad_t, bad_a, bad_e));
    check(longs == nlong, req, $sformatf("code %h: %0d long pulses, expected %0d",
                                         code_x, longs, nlong));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; show_en = 1'b0; status_code = 4'h0;
    repeat (3) @(negedge clk);
    check(led === 1'b0, "R1", $sformatf("led=%b during reset, expected 0", led));
    rst = 1'b0;

    // R2: code present but reporting disabled
    status_code = 4'hF;
    expect_dark(50, "R2");

    // Table walk: back-to-back frames, code changes mid-frame (t=10) or
    // exactly at the last dead-time edge (t=FRAME-1). Covers R3 R4 R5 R6 R7.
    show_en = 1'b1; status_code = VEC[0][7:4];
    for (int i = 0; i < 8; i++) begin
      logic [3:0] nxt;
      int         at;
      logic       en_after;
      if (i == 7) begin
        at = 40; en_after = 1'b0; nxt = 4'h0;
      end else begin
        at = (i % 2 == 1) ? FRAME - 1 : 10;
        en_after = 1'b1;
        nxt = VEC[i+1][7:4];
      end
      run_frame(VEC[i][7:4], int'(VEC[i][3:0]), at, en_after, nxt, "R3/R4/R5/R6/R7");
    end
    // R8: withdrawn mid-frame, frame completed above, now dark
    expect_dark(2 * FRAME, "R8");

    // R8: single-cycle enable still yields one full frame
    show_en = 1'b1; status_code = 4'h9;
    run_frame(4'h9, 2, 0, 1'b0, 4'h9, "R8");
    expect_dark(FRAME, "R8");

    // R8: enable drops exactly at the last dead-time edge
    show_en = 1'b1; status_code = 4'h6;
    run_frame(4'h6, 2, FRAME - 1, 1'b0, 4'h6, "R8");
    expect_dark(FRAME, "R8");

    // R7: new code on the boundary edge is used for the next frame
    show_en = 1'b1; status_code = 4'hC;
    run_frame(4'hC, 2, FRAME - 1, 1'b1, 4'h3, "R7");
    run_frame(4'h3, 2, 5, 1'b0, 4'h3, "R7");
    expect_dark(FRAME, "R7");

    // R1: reset in the middle of a frame
    show_en = 1'b1; status_code = 4'hF;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(led === 1'b0, "R1", $sformatf("led=%b after mid-frame reset, expected 0", led));
    repeat (2) @(negedge clk);
    check(led === 1'b0, "R1", $sformatf("led=%b held in reset, expected 0", led));
    rst = 1'b0; status_code = 4'h5;
    run_frame(4'h5, 2, 30, 1'b0, 4'h5, "R1");
    expect_dark(FRAME, "R1");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule